// File: doc/BRIEF.md
# Dual-Port Flagged Register File

This block is a sixteen-byte register file that two agents share: a host on the primary port and a local processor on the secondary port. Each port has a request channel and a read-response channel, and both channels use a valid/ready handshake. Bytes 2 to 15 hold general data. Bytes 0 and 1 hold one "written" flag for each general byte. The hardware sets a byte's flag whenever either port stores into that byte. The flag stays set until software writes the flag byte to clear it. Bits 1:0 of byte 0 are write guards. Only the processor can change them, and they can lock the host out of the two top bytes. The two agents can therefore use bytes 14 and 15 as a mailbox that the host cannot overwrite.

The primary port uses a 4-bit byte index. The secondary port uses a 6-bit address, and only the window 0x30 to 0x3F reaches the file. Both ports carry 8-bit data.

Back-pressure works the same way on both ports. A port accepts a request when `*_req_valid` and `*_req_ready` are both high. `*_req_ready` is low only while a read response is waiting and the consumer holds `*_rsp_ready` low. A pending response keeps its data stable until the consumer accepts it. The requester may hold a request valid across stalled cycles. Writes return no response.

Top module: `dpfr_top`

## Requirements
- R1: After reset every byte reads 0x00, and no response is pending on either port.
- R2: Primary index k and secondary address 0x30+k reach the same byte. A secondary write to an address outside 0x30..0x3F changes nothing. A secondary read outside that window returns 0x00.
- R3: When either port writes a general byte k (2..15), the byte's flag is set. The flag sits at byte 0 bit k for k in 2..7, and at byte 1 bit k-8 for k in 8..15. The flag is visible to any request accepted after that write.
- R4: Reading a byte leaves every flag unchanged. Writing a flag byte loads its flag bits with the written value, so writing 0 clears them.
- R5: Only the secondary port can change byte 0 bits 1:0. A primary write to byte 0 updates bits 7:2 and leaves bits 1:0 unchanged.
- R6: While byte 0 bit 0 is 1, primary writes to byte 14 are dropped. While byte 0 bit 1 is 1, primary writes to byte 15 are dropped. A dropped write changes neither the data nor the flag. Secondary writes are never dropped.
- R7: If both ports write the same byte in one cycle, the byte takes the secondary port's value.
- R8: If a data write sets a flag in the same cycle that a flag-byte write would clear it, the flag ends up set.
- R9: A read accepted at an edge returns its data with `*_rsp_valid` high in the next cycle. The data is the value the byte held before any write accepted at that same edge.
- R10: `*_req_ready` equals NOT `*_rsp_valid` OR `*_rsp_ready`. A response stalled by a low `*_rsp_ready` holds its data stable.
- R11: An accepted write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req_valid | input | 1 | Primary request valid |
| p_req_ready | output | 1 | Primary request ready |
| p_req_write | input | 1 | Primary request is a write (1) or a read (0) |
| p_req_addr | input | 4 | Primary byte index |
| p_req_wdata | input | 8 | Primary write data |
| p_rsp_valid | output | 1 | Primary read data valid |
| p_rsp_ready | input | 1 | Primary read data taken |
| p_rsp_data | output | 8 | Primary read data |
| s_req_valid | input | 1 | Secondary request valid |
| s_req_ready | output | 1 | Secondary request ready |
| s_req_write | input | 1 | Secondary request is a write (1) or a read (0) |
| s_req_addr | input | 6 | Secondary address, file at 0x30..0x3F |
| s_req_wdata | input | 8 | Secondary write data |
| s_rsp_valid | output | 1 | Secondary read data valid |
| s_rsp_ready | input | 1 | Secondary read data taken |
| s_rsp_data | output | 8 | Secondary read data |

## Verification
The bench sweeps every index on both ports and all 64 secondary addresses, and checks each read against an arithmetic model. A decoder that aliased addresses outside the window would corrupt bytes, and one that missed the top nibble would lose writes. All four write-guard settings are tried against host writes to bytes 14 and 15. Host writes to the guard bits themselves are also tried. A guard mapped to the wrong byte, or a blocked write that still set its flag, shows up as a wrong readback. Same-cycle collisions check the secondary-port priority, the rule that a flag set beats a flag clear, and the rule that reads see the value from before the write. A stalled response is held for several cycles while a second request waits. A design that dropped or replaced the data during the stall fails that test.

// File: rtl/dpfr_pkg.sv
package dpfr_pkg;
  parameter int NUM_BYTES_D = 16;
  parameter int DATA_W_D    = 8;
  parameter int PRI_AW_D    = 4;
  parameter int SEC_AW_D    = 6;
  parameter logic [SEC_AW_D-1:0] SEC_BASE_D = 6'h30;
endpackage

// File: rtl/dpfr_port.sv
module dpfr_port #(
  parameter int AW     = 4,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_byte
);
  logic              hit;
  logic              accept;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  generate
    if (AW > IDX_W) begin : g_window
      assign hit = (req_addr[AW-1:IDX_W] == BASE[AW-1:IDX_W]);
    end else begin : g_direct
      assign hit = 1'b1;
    end
  endgenerate

  assign idx       = req_addr[IDX_W-1:0];
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write && hit;
  assign wr_data   = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= hit ? rd_byte : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R10: a stalled response keeps its data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R10: no request is taken while a response is stalled
  a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R11: writes never raise a response
  a_r11_no_wr_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (!rsp_valid || rsp_ready)) |=> !rsp_valid);
endmodule

// File: rtl/dpfr_core.sv
module dpfr_core #(
  parameter int NUM_BYTES = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_we,
  input  logic [IDX_W-1:0]  pri_idx,
  input  logic [DATA_W-1:0] pri_wd,
  input  logic              sec_we,
  input  logic [IDX_W-1:0]  sec_idx,
  input  logic [DATA_W-1:0] sec_wd,
  output logic [DATA_W-1:0] pri_rd,
  output logic [DATA_W-1:0] sec_rd
);
  localparam int FLAG_BYTES = NUM_BYTES / DATA_W;
  localparam int FIRST_GP   = FLAG_BYTES;
  localparam int GUARD_N    = 2;
  localparam int PROT_LO    = NUM_BYTES - GUARD_N;

  logic [DATA_W-1:0]    gp_q [NUM_BYTES-1:FIRST_GP];
  logic [NUM_BYTES-1:0] flag_q;
  logic [NUM_BYTES-1:0] set_vec;
  logic                 pri_blk;
  logic                 pri_eff;

  always_comb begin
    pri_blk = 1'b0;
    for (int g = 0; g < GUARD_N; g++) begin
      if (pri_idx == IDX_W'(PROT_LO + g) && flag_q[g]) pri_blk = 1'b1;
    end
  end
  assign pri_eff = pri_we && !pri_blk;

  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_flag
      localparam int FB = i / DATA_W;
      localparam int FP = i % DATA_W;
      if (i < GUARD_N) begin : g_guard
        assign set_vec[i] = 1'b0;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                  flag_q[i] <= 1'b0;
          else if (sec_we && sec_idx == IDX_W'(FB))    flag_q[i] <= sec_wd[FP];
        end
      end else if (i < FIRST_GP) begin : g_spare
        assign set_vec[i] = 1'b0;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                  flag_q[i] <= 1'b0;
          else if (sec_we && sec_idx == IDX_W'(FB))    flag_q[i] <= sec_wd[FP];
          else if (pri_eff && pri_idx == IDX_W'(FB))   flag_q[i] <= pri_wd[FP];
        end
      end else begin : g_track
        assign set_vec[i] = (pri_eff && pri_idx == IDX_W'(i)) ||
                            (sec_we && sec_idx == IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                  flag_q[i] <= 1'b0;
          else if (set_vec[i])                         flag_q[i] <= 1'b1;
          else if (sec_we && sec_idx == IDX_W'(FB))    flag_q[i] <= sec_wd[FP];
          else if (pri_eff && pri_idx == IDX_W'(FB))   flag_q[i] <= pri_wd[FP];
        end
        // R3: a data write leaves its flag set
        a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
          set_vec[i] |=> flag_q[i]);
        // R4: with no write to its flag byte, a set flag stays set
        a_r4_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
          (flag_q[i] && !(sec_we && sec_idx == IDX_W'(FB)) &&
           !(pri_we && pri_idx == IDX_W'(FB))) |=> flag_q[i]);
      end
    end

    for (genvar k = FIRST_GP; k < NUM_BYTES; k++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    gp_q[k] <= '0;
        else if (sec_we && sec_idx == IDX_W'(k))       gp_q[k] <= sec_wd;
        else if (pri_eff && pri_idx == IDX_W'(k))      gp_q[k] <= pri_wd;
      end
      if (k >= PROT_LO) begin : g_prot_chk
        // R6: a dropped host write leaves the guarded byte alone
        a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
          (pri_we && pri_idx == IDX_W'(k) && flag_q[k-PROT_LO] &&
           !(sec_we && sec_idx == IDX_W'(k))) |=> $stable(gp_q[k]));
      end
    end
  endgenerate

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] a);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int f = 0; f < FLAG_BYTES; f++) begin
      if (a == IDX_W'(f)) v = flag_q[f*DATA_W +: DATA_W];
    end
    for (int k = FIRST_GP; k < NUM_BYTES; k++) begin
      if (a == IDX_W'(k)) v = gp_q[k];
    end
    return v;
  endfunction

  assign pri_rd = pick(pri_idx);
  assign sec_rd = pick(sec_idx);

  // R5: the host cannot move the guard bits
  a_r5_guard_host: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_we && sec_idx == '0) |=> $stable(flag_q[GUARD_N-1:0]));
  // R7: on a shared target the processor value lands
  a_r7_sec_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_we && sec_we && pri_idx == sec_idx && sec_idx >= IDX_W'(FIRST_GP))
    |=> (pick($past(sec_idx)) == $past(sec_wd)));
endmodule

// File: rtl/dpfr_top.sv
module dpfr_top
  import dpfr_pkg::*;
#(
  parameter int NUM_BYTES = NUM_BYTES_D,
  parameter int DATA_W    = DATA_W_D,
  parameter int PRI_AW    = PRI_AW_D,
  parameter int SEC_AW    = SEC_AW_D,
  parameter logic [SEC_AW-1:0] SEC_BASE = SEC_BASE_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_req_valid,
  output logic              p_req_ready,
  input  logic              p_req_write,
  input  logic [PRI_AW-1:0] p_req_addr,
  input  logic [DATA_W-1:0] p_req_wdata,
  output logic              p_rsp_valid,
  input  logic              p_rsp_ready,
  output logic [DATA_W-1:0] p_rsp_data,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic              s_req_write,
  input  logic [SEC_AW-1:0] s_req_addr,
  input  logic [DATA_W-1:0] s_req_wdata,
  output logic              s_rsp_valid,
  input  logic              s_rsp_ready,
  output logic [DATA_W-1:0] s_rsp_data
);
  localparam int IDX_W = $clog2(NUM_BYTES);

  logic              pri_we, sec_we;
  logic [IDX_W-1:0]  pri_idx, sec_idx;
  logic [DATA_W-1:0] pri_wd, sec_wd, pri_rd, sec_rd;

  dpfr_port #(.AW(PRI_AW), .IDX_W(IDX_W), .DATA_W(DATA_W), .BASE('0)) u_pri (
    .clk, .rst_n,
    .req_valid(p_req_valid), .req_ready(p_req_ready), .req_write(p_req_write),
    .req_addr(p_req_addr), .req_wdata(p_req_wdata),
    .rsp_valid(p_rsp_valid), .rsp_ready(p_rsp_ready), .rsp_data(p_rsp_data),
    .wr_en(pri_we), .idx(pri_idx), .wr_data(pri_wd), .rd_byte(pri_rd));

  dpfr_port #(.AW(SEC_AW), .IDX_W(IDX_W), .DATA_W(DATA_W), .BASE(SEC_BASE)) u_sec (
    .clk, .rst_n,
    .req_valid(s_req_valid), .req_ready(s_req_ready), .req_write(s_req_write),
    .req_addr(s_req_addr), .req_wdata(s_req_wdata),
    .rsp_valid(s_rsp_valid), .rsp_ready(s_rsp_ready), .rsp_data(s_rsp_data),
    .wr_en(sec_we), .idx(sec_idx), .wr_data(sec_wd), .rd_byte(sec_rd));

  dpfr_core #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .clk, .rst_n,
    .pri_we, .pri_idx, .pri_wd,
    .sec_we, .sec_idx, .sec_wd,
    .pri_rd, .sec_rd);

  // R1: no response straight out of reset
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!p_rsp_valid && !s_rsp_valid));
endmodule

// File: tb/dpfr_top_tb_top.sv
module dpfr_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_req_valid = 0, p_req_write = 0, p_rsp_ready = 1;
  logic [3:0] p_req_addr = '0;
  logic [7:0] p_req_wdata = '0;
  logic s_req_valid = 0, s_req_write = 0, s_rsp_ready = 1;
  logic [5:0] s_req_addr = '0;
  logic [7:0] s_req_wdata = '0;
  logic p_req_ready, p_rsp_valid, s_req_ready, s_rsp_valid;
  logic [7:0] p_rsp_data, s_rsp_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] mem [16];

  always #5 clk = ~clk;

  dpfr_top dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // model of one cycle's writes; secondary hit only inside 0x30..0x3F
  task automatic apply(input bit pv, input logic [3:0] pa, input logic [7:0] pd,
                       input bit sv, input logic [5:0] sa, input logic [7:0] sd);
    logic [7:0] m [16];
    logic [15:0] setv;
    bit pe;
    m = mem; setv = '0;
    pe = pv && !(pa == 4'd14 && mem[0][0]) && !(pa == 4'd15 && mem[0][1]);
    if (pe) begin
      if (pa == 0) m[0] = {pd[7:2], mem[0][1:0]};
      else m[pa] = pd;
      if (pa >= 2) setv[pa] = 1'b1;
    end
    if (sv && sa[5:4] == 2'b11) begin
      m[sa[3:0]] = sd;
      if (sa[3:0] >= 2) setv[sa[3:0]] = 1'b1;
    end
    m[0] = m[0] | {setv[7:2], 2'b00};
    m[1] = m[1] | setv[15:8];
    mem = m;
  endtask

  task automatic pw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    p_req_valid = 1; p_req_write = 1; p_req_addr = a; p_req_wdata = d;
    @(negedge clk);
    p_req_valid = 0;
    apply(1, a, d, 0, '0, '0);
  endtask

  task automatic sw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    s_req_valid = 1; s_req_write = 1; s_req_addr = a; s_req_wdata = d;
    @(negedge clk);
    s_req_valid = 0;
    apply(0, '0, '0, 1, a, d);
  endtask

  task automatic both_w(input logic [3:0] pa, input logic [7:0] pd,
                        input logic [5:0] sa, input logic [7:0] sd);
    @(negedge clk);
    p_req_valid = 1; p_req_write = 1; p_req_addr = pa; p_req_wdata = pd;
    s_req_valid = 1; s_req_write = 1; s_req_addr = sa; s_req_wdata = sd;
    @(negedge clk);
    p_req_valid = 0; s_req_valid = 0;
    apply(1, pa, pd, 1, sa, sd);
  endtask

  task automatic pr(input logic [3:0] a, input string tag);
    @(negedge clk);
    p_req_valid = 1; p_req_write = 0; p_req_addr = a;
    @(negedge clk);
    p_req_valid = 0;
    chk({tag, " p_rsp_valid"}, {7'd0, p_rsp_valid}, 8'd1);
    chk($sformatf("%s pri byte %0d", tag, a), p_rsp_data, mem[a]);
  endtask

  task automatic sr(input logic [5:0] a, input string tag);
    @(negedge clk);
    s_req_valid = 1; s_req_write = 0; s_req_addr = a;
    @(negedge clk);
    s_req_valid = 0;
    chk({tag, " s_rsp_valid"}, {7'd0, s_rsp_valid}, 8'd1);
    chk($sformatf("%s sec addr %02h", tag, a), s_rsp_data,
        (a[5:4] == 2'b11) ? mem[a[3:0]] : 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 p_rsp_valid", {7'd0, p_rsp_valid}, 8'd0);
    chk("R1 s_rsp_valid", {7'd0, s_rsp_valid}, 8'd0);
    for (int i = 0; i < 16; i++) pr(i[3:0], "R1");

    // R2 R3 primary sweep, readback both sides
    for (int i = 2; i < 16; i++) pw(i[3:0], 8'((i * 37 + 5) & 255));
    chk("R11 p_rsp_valid after write", {7'd0, p_rsp_valid}, 8'd0);
    for (int i = 0; i < 16; i++) pr(i[3:0], "R3");
    for (int i = 0; i < 16; i++) sr(6'h30 + 6'(i), "R2");

    // R4 reads do not clear, writing 0 clears
    pr(4'd0, "R4 still set"); pr(4'd1, "R4 still set");
    pw(4'd0, 8'h00); pw(4'd1, 8'h00);
    pr(4'd0, "R4 clear"); pr(4'd1, "R4 clear");

    // R2 secondary full 6-bit address sweep
    for (int a = 0; a < 64; a++) sw(6'(a), 8'((a * 11 + 3) & 255));
    for (int a = 0; a < 64; a++) sr(6'(a), "R2 sweep");
    sw(6'h30, 8'h00); sw(6'h31, 8'h00);

    // R5 host cannot touch guard bits
    pw(4'd0, 8'hFF); pr(4'd0, "R5 host sets");
    sw(6'h30, 8'h03); pw(4'd0, 8'h00); pr(4'd0, "R5 host clears");
    sr(6'h30, "R5 sec view");

    // R6 all guard settings vs host writes to 14,15, plus processor writes
    for (int g = 0; g < 4; g++) begin
      sw(6'h30, 8'(g));
      sw(6'h31, 8'h00);
      pw(4'd14, 8'(8'h40 + g)); pw(4'd15, 8'(8'h80 + g));
      pr(4'd14, "R6"); pr(4'd15, "R6"); pr(4'd1, "R6 flags");
      sw(6'h3E, 8'(8'hC0 + g)); pr(4'd14, "R6 sec");
    end
    sw(6'h30, 8'h00);

    // R7 collision on a data byte and on byte 0
    both_w(4'd9, 8'h11, 6'h39, 8'h22); pr(4'd9, "R7");
    both_w(4'd0, 8'hFC, 6'h30, 8'h04); pr(4'd0, "R7 byte0");

    // R8 set beats same-cycle clear
    sw(6'h31, 8'h00);
    both_w(4'd1, 8'h00, 6'h3B, 8'h5A); pr(4'd1, "R8 pri clear");
    both_w(4'd12, 8'h66, 6'h31, 8'h00); pr(4'd1, "R8 sec clear");

    // R9 read sees pre-write value
    pw(4'd5, 8'hA5);
    begin
      logic [7:0] old;
      old = mem[5];
      @(negedge clk);
      p_req_valid = 1; p_req_write = 0; p_req_addr = 4'd5;
      s_req_valid = 1; s_req_write = 1; s_req_addr = 6'h35; s_req_wdata = 8'h3C;
      @(negedge clk);
      p_req_valid = 0; s_req_valid = 0;
      apply(0, '0, '0, 1, 6'h35, 8'h3C);
      chk("R9 read before write", p_rsp_data, old);
    end
    pr(4'd5, "R9 after");

    // R10 back-pressure
    @(negedge clk);
    s_rsp_ready = 0; s_req_valid = 1; s_req_write = 0; s_req_addr = 6'h35;
    @(negedge clk);
    chk("R10 valid", {7'd0, s_rsp_valid}, 8'd1);
    chk("R10 ready low", {7'd0, s_req_ready}, 8'd0);
    chk("R10 data", s_rsp_data, mem[5]);
    s_req_addr = 6'h3B;
    @(negedge clk);
    chk("R10 held", s_rsp_data, mem[5]);
    chk("R10 still low", {7'd0, s_req_ready}, 8'd0);
    s_rsp_ready = 1;
    @(negedge clk);
    s_req_valid = 0;
    chk("R10 next", s_rsp_data, mem[11]);
    chk("R10 next valid", {7'd0, s_rsp_valid}, 8'd1);
    @(negedge clk);
    chk("R10 drained", {7'd0, s_rsp_valid}, 8'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule